// File: doc/BRIEF.md
# Dual-Width Instruction-State Program Counter Sequencer

This block holds the program counter and the instruction-state flag of a core that runs in two instruction states. One is a wide state with 32-bit instructions. The other is a compact state with 16-bit instructions. On each clock the block takes at most one control-flow request and computes the next PC and the next state. The request is one of four kinds: a sequential step, a PC-relative branch, a register-indirect branch that can switch state, or an exception entry. Operand values arrive already decoded and already read from the register file.

The state flag follows a simple rule. Only a register-indirect branch or an exception entry can change it. An indirect branch takes the new state from bit 0 of its target. An exception always lands in wide state. When a relative or indirect branch is marked as a call, the block also produces a return address. That address carries the caller's state in bit 0, so an indirect branch back through it restores both the address and the state. This works whichever states the caller and the callee use.

If more than one request strobe is high in a cycle, the block rejects the cycle: it keeps the PC and the state and raises an error flag.

Top module: `istate_pc_seq`

## Requirements
- R1: A lone sequential request adds 4 to the PC in wide state (`compact`=0) and 2 in compact state (`compact`=1). The result is visible after the next rising clock edge.
- R2: A lone relative request adds the sign-extended `rel_imm`, shifted left by 2 in wide state or by 1 in compact state, to the current PC.
- R3: A lone indirect request sets `compact` to bit 0 of `ind_tgt`. It loads the PC with `ind_tgt` with bit 0 cleared. When bit 0 of `ind_tgt` is 0, bit 1 is cleared as well.
- R4: Sequential and relative requests never change `compact`.
- R5: A lone exception request clears `compact` and loads the PC with `exc_vec` with bits 1:0 cleared.
- R6: A relative or indirect request with `call_en` high raises `link_vld` for one cycle. In that cycle `link` equals the old PC plus the step of the old state (4 or 2), with bit 0 set to the old `compact` value. Any other accepted cycle leaves `link_vld` low.
- R7: An indirect request whose target is a value previously produced on `link` restores the caller's PC and state. This holds for all four caller/callee combinations of wide and compact state.
- R8: While `rst_n` is low, the outputs are PC 0, wide state, `link_vld` 0 and `err` 0.
- R9: When two or more of `req_seq`, `req_rel`, `req_ind` and `req_exc` are high in one cycle, `err` is high after the edge, PC and `compact` are unchanged and `link_vld` is 0.
- R10: A cycle with no request strobe keeps the PC and `compact` and clears `err` and `link_vld`.
- R11: The PC is always a multiple of 4 in wide state and a multiple of 2 in compact state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_seq | input | 1 | Sequential advance request |
| req_rel | input | 1 | PC-relative branch request |
| req_ind | input | 1 | Register-indirect, state-selecting branch request |
| req_exc | input | 1 | Exception entry request |
| call_en | input | 1 | Marks a relative or indirect branch as a call |
| rel_imm | input | IMM_W | Signed branch offset, in instructions |
| ind_tgt | input | PC_W | Indirect branch target register value |
| exc_vec | input | PC_W | Exception vector address |
| pc | output | PC_W | Current program counter |
| compact | output | 1 | State flag: 1 compact, 0 wide |
| link | output | PC_W | Return address with state in bit 0 |
| link_vld | output | 1 | `link` was written by the last request |
| err | output | 1 | Last cycle had conflicting request strobes |

## Verification
The assertions assume the strobes are synchronous to `clk` and hold steady across each edge. They also assume that `rel_imm` fits in fewer bits than the PC, so that shifted offsets wrap only modulo the PC width. The bench changes inputs only on falling edges and keeps every offset well inside the PC range. A chained table of requests exercises all four state pairings of a call and its return. Directed cycles then drive conflicting strobes and idle cycles, with vectors and targets whose low bits are set.

// File: rtl/istate_pkg.sv
package istate_pkg;

    // Decoded kind of the control-flow request seen in one cycle
    typedef enum logic [2:0] {
        RK_IDLE = 3'd0,
        RK_SEQ  = 3'd1,
        RK_REL  = 3'd2,
        RK_IND  = 3'd3,
        RK_EXC  = 3'd4,
        RK_BAD  = 3'd5
    } req_kind_e;

    localparam int unsigned NUM_REQ = 4;

    // Bit positions of the strobes in the request vector
    localparam int unsigned BIT_SEQ = 0;
    localparam int unsigned BIT_REL = 1;
    localparam int unsigned BIT_IND = 2;
    localparam int unsigned BIT_EXC = 3;

endpackage

// File: rtl/pcs_req_decode.sv
module pcs_req_decode
    import istate_pkg::*;
(
    input  logic [NUM_REQ-1:0] req,
    output req_kind_e          kind
);

    logic [$clog2(NUM_REQ+1)-1:0] n_set;

    always_comb begin
        n_set = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            n_set = n_set + {{($bits(n_set)-1){1'b0}}, req[i]};
        end
    end

    always_comb begin
        kind = RK_IDLE;
        if (n_set > 1) begin
            kind = RK_BAD;
        end else if (req[BIT_SEQ]) begin
            kind = RK_SEQ;
        end else if (req[BIT_REL]) begin
            kind = RK_REL;
        end else if (req[BIT_IND]) begin
            kind = RK_IND;
        end else if (req[BIT_EXC]) begin
            kind = RK_EXC;
        end
    end

endmodule

// File: rtl/pcs_offset.sv
// Step and branch-offset generator; IMM_W must be below PC_W - 2.
module pcs_offset #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IMM_W = 24
) (
    input  logic             cst,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  addend,
    output logic [PC_W-1:0]  step
);

    localparam int unsigned EXT_W = PC_W - IMM_W;

    logic [PC_W-1:0] imm_x;

    assign imm_x = {{EXT_W{imm[IMM_W-1]}}, imm};
    // 4 in wide state, 2 in compact state
    assign step  = {{(PC_W-3){1'b0}}, ~cst, cst, 1'b0};

    always_comb begin
        if (!use_imm) begin
            addend = step;
        end else if (cst) begin
            addend = imm_x << 1;
        end else begin
            addend = imm_x << 2;
        end
    end

endmodule

// File: rtl/pcs_target.sv
module pcs_target #(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0] tgt,
    input  logic [PC_W-1:0] vec,
    output logic [PC_W-1:0] ind_pc,
    output logic            ind_cst,
    output logic [PC_W-1:0] exc_pc
);

    localparam logic [PC_W-1:0] WORD_MASK = ~{{(PC_W-2){1'b0}}, 2'b11};

    // bit 0 selects the state; a wide target also drops bit 1
    assign ind_cst = tgt[0];
    assign ind_pc  = {tgt[PC_W-1:2], tgt[1] & tgt[0], 1'b0};
    assign exc_pc  = vec & WORD_MASK;

endmodule

// File: rtl/istate_pc_seq.sv
module istate_pc_seq
    import istate_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IMM_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_seq,
    input  logic             req_rel,
    input  logic             req_ind,
    input  logic             req_exc,
    input  logic             call_en,
    input  logic [IMM_W-1:0] rel_imm,
    input  logic [PC_W-1:0]  ind_tgt,
    input  logic [PC_W-1:0]  exc_vec,
    output logic [PC_W-1:0]  pc,
    output logic             compact,
    output logic [PC_W-1:0]  link,
    output logic             link_vld,
    output logic             err
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            cst;
        logic [PC_W-1:0] link;
        logic            link_vld;
        logic            err;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;

    req_kind_e       kind;
    logic [PC_W-1:0] addend;
    logic [PC_W-1:0] step;
    logic [PC_W-1:0] ind_pc;
    logic            ind_cst;
    logic [PC_W-1:0] exc_pc;
    logic [PC_W-1:0] ret_addr;

    pcs_req_decode u_dec (
        .req  ({req_exc, req_ind, req_rel, req_seq}),
        .kind (kind)
    );

    pcs_offset #(.PC_W(PC_W), .IMM_W(IMM_W)) u_off (
        .cst     (cur_q.cst),
        .use_imm (kind == RK_REL),
        .imm     (rel_imm),
        .addend  (addend),
        .step    (step)
    );

    pcs_target #(.PC_W(PC_W)) u_tgt (
        .tgt     (ind_tgt),
        .vec     (exc_vec),
        .ind_pc  (ind_pc),
        .ind_cst (ind_cst),
        .exc_pc  (exc_pc)
    );

    // return address carries the caller's state in bit 0
    assign ret_addr = (cur_q.pc + step) | {{(PC_W-1){1'b0}}, cur_q.cst};

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.link_vld = 1'b0;
        nxt_d.err      = 1'b0;
        unique case (kind)
            RK_SEQ: begin
                nxt_d.pc = cur_q.pc + addend;
            end
            RK_REL: begin
                nxt_d.pc = cur_q.pc + addend;
                if (call_en) begin
                    nxt_d.link     = ret_addr;
                    nxt_d.link_vld = 1'b1;
                end
            end
            RK_IND: begin
                nxt_d.pc  = ind_pc;
                nxt_d.cst = ind_cst;
                if (call_en) begin
                    nxt_d.link     = ret_addr;
                    nxt_d.link_vld = 1'b1;
                end
            end
            RK_EXC: begin
                nxt_d.pc  = exc_pc;
                nxt_d.cst = 1'b0;
            end
            RK_BAD: begin
                nxt_d.err = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc       = cur_q.pc;
    assign compact  = cur_q.cst;
    assign link     = cur_q.link;
    assign link_vld = cur_q.link_vld;
    assign err      = cur_q.err;

    logic [2:0] n_req;
    logic       lone;
    assign n_req = {2'b0, req_seq} + {2'b0, req_rel} + {2'b0, req_ind} + {2'b0, req_exc};
    assign lone  = (n_req == 3'd1);

    a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lone && req_seq) |=> (pc == $past(pc) + ($past(compact) ? 2 : 4)));

    a_r3_ind_state: assert property (@(posedge clk) disable iff (!rst_n)
        (lone && req_ind) |=> (compact == $past(ind_tgt[0])));

    a_r4_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lone && (req_seq || req_rel)) |=> (compact == $past(compact)));

    a_r5_exc_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (lone && req_exc) |=> (!compact && pc[1:0] == 2'b00 &&
                               pc[PC_W-1:2] == $past(exc_vec[PC_W-1:2])));

    a_r6_link_state: assert property (@(posedge clk) disable iff (!rst_n)
        (lone && (req_rel || req_ind) && call_en) |=>
            (link_vld && link[0] == $past(compact)));

    a_r9_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (n_req > 3'd1) |=> (err && !link_vld && $stable(pc) && $stable(compact)));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (n_req == 3'd0) |=> (!err && !link_vld && $stable(pc) && $stable(compact)));

    a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (compact ? (pc[0] == 1'b0) : (pc[1:0] == 2'b00)));

endmodule

// File: tb/sim_istate_pc_seq.sv
module sim_istate_pc_seq;

    localparam int PC_W  = 32;
    localparam int IMM_W = 24;
    localparam int NVEC  = 20;

    typedef struct packed {
        logic [1:0]  op;   // 0 seq, 1 rel, 2 ind, 3 exc
        logic        call;
        logic [23:0] imm;
        logic [31:0] arg;
        logic [31:0] pc;
        logic        st;
        logic [31:0] lk;
    } vec_t;

    // chained from reset: pc 0, wide state
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 1'b0, 24'h0,      32'h0,   32'h4,   1'b0, 32'h0},   // R1 wide
        '{2'd0, 1'b0, 24'h0,      32'h0,   32'h8,   1'b0, 32'h0},
        '{2'd1, 1'b0, 24'h3,      32'h0,   32'h14,  1'b0, 32'h0},   // R2 wide +
        '{2'd1, 1'b0, 24'hFFFFFE, 32'h0,   32'hC,   1'b0, 32'h0},   // R2 wide -
        '{2'd2, 1'b1, 24'h0,      32'h101, 32'h100, 1'b1, 32'h10},  // R7 wide->compact call
        '{2'd0, 1'b0, 24'h0,      32'h0,   32'h102, 1'b1, 32'h0},   // R1 compact
        '{2'd1, 1'b0, 24'h5,      32'h0,   32'h10C, 1'b1, 32'h0},   // R2 compact +
        '{2'd1, 1'b1, 24'hFFFFFF, 32'h0,   32'h10A, 1'b1, 32'h10F}, // R7 compact->compact call
        '{2'd2, 1'b0, 24'h0,      32'h10,  32'h10,  1'b0, 32'h0},   // R7 return to wide
        '{2'd2, 1'b0, 24'h0,      32'h10F, 32'h10E, 1'b1, 32'h0},   // R7 return to compact
        '{2'd2, 1'b0, 24'h0,      32'h203, 32'h202, 1'b1, 32'h0},   // R3 compact keeps bit 1
        '{2'd2, 1'b0, 24'h0,      32'h306, 32'h304, 1'b0, 32'h0},   // R3 wide drops bit 1
        '{2'd3, 1'b0, 24'h0,      32'h18,  32'h18,  1'b0, 32'h0},   // R5 from wide
        '{2'd2, 1'b0, 24'h0,      32'h41,  32'h40,  1'b1, 32'h0},
        '{2'd3, 1'b0, 24'h0,      32'h1E,  32'h1C,  1'b0, 32'h0},   // R5 from compact, low bits set
        '{2'd1, 1'b1, 24'h4,      32'h0,   32'h2C,  1'b0, 32'h20},  // R7 wide->wide call
        '{2'd2, 1'b0, 24'h0,      32'h20,  32'h20,  1'b0, 32'h0},
        '{2'd2, 1'b0, 24'h0,      32'h51,  32'h50,  1'b1, 32'h0},
        '{2'd2, 1'b1, 24'h0,      32'h200, 32'h200, 1'b0, 32'h53},  // R7 compact->wide call
        '{2'd2, 1'b0, 24'h0,      32'h53,  32'h52,  1'b1, 32'h0}    // R7 back in compact
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_seq = 1'b0, req_rel = 1'b0, req_ind = 1'b0, req_exc = 1'b0;
    logic             call_en = 1'b0;
    logic [IMM_W-1:0] rel_imm = '0;
    logic [PC_W-1:0]  ind_tgt = '0, exc_vec = '0;
    logic [PC_W-1:0]  pc, link;
    logic             compact, link_vld, err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    istate_pc_seq #(.PC_W(PC_W), .IMM_W(IMM_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_seq(req_seq), .req_rel(req_rel), .req_ind(req_ind), .req_exc(req_exc),
        .call_en(call_en), .rel_imm(rel_imm), .ind_tgt(ind_tgt), .exc_vec(exc_vec),
        .pc(pc), .compact(compact), .link(link), .link_vld(link_vld), .err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // drive on the falling edge, look 1 ns after the rising edge
    task automatic drive(input logic s, input logic r, input logic i, input logic e,
                         input logic c, input logic [23:0] im, input logic [31:0] a);
        @(negedge clk);
        req_seq = s; req_rel = r; req_ind = i; req_exc = e;
        call_en = c; rel_imm = im; ind_tgt = a; exc_vec = a;
        @(posedge clk);
        #1;
    endtask

    function automatic string pc_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3/R7";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R8 pc", pc, 32'h0);
        chk("R8 state", {31'b0, compact}, 32'h0);
        chk("R8 link_vld", {31'b0, link_vld}, 32'h0);
        chk("R8 err", {31'b0, err}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            drive(TBL[k].op == 2'd0, TBL[k].op == 2'd1, TBL[k].op == 2'd2, TBL[k].op == 2'd3,
                  TBL[k].call, TBL[k].imm, TBL[k].arg);
            chk(pc_tag(TBL[k].op), pc, TBL[k].pc);
            chk((TBL[k].op < 2'd2) ? "R4 state" : "R3/R5 state", {31'b0, compact}, {31'b0, TBL[k].st});
            chk("R6 link_vld", {31'b0, link_vld}, {31'b0, TBL[k].call});
            if (TBL[k].call) chk("R6 link", link, TBL[k].lk);
            chk("R11 align", {30'b0, pc[1:0]}, {30'b0, pc[1] & TBL[k].st, 1'b0});
        end

        // conflicting strobes: PC 0x52, compact, link unchanged
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'h0, 32'h40);
        chk("R9 err", {31'b0, err}, 32'h1);
        chk("R9 pc", pc, 32'h52);
        chk("R9 state", {31'b0, compact}, 32'h1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h7, 32'h300);
        chk("R9 err", {31'b0, err}, 32'h1);
        chk("R9 link_vld", {31'b0, link_vld}, 32'h0);
        chk("R9 link", link, 32'h53);
        chk("R9 pc", pc, 32'h52);

        // idle cycles hold
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 32'h0);
        chk("R10 err", {31'b0, err}, 32'h0);
        chk("R10 pc", pc, 32'h52);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 24'h0, 32'h0);
        chk("R10 pc", pc, 32'h52);
        chk("R10 state", {31'b0, compact}, 32'h1);
        chk("R10 link_vld", {31'b0, link_vld}, 32'h0);

        // reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R8 pc", pc, 32'h0);
        chk("R8 state", {31'b0, compact}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 32'h0);
        chk("R1 after reset", pc, 32'h4);
        @(negedge clk);
        req_seq = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule